// File: doc/BRIEF.md
# Split-Capable Reload/Capture Timer

This block is a 16-bit up-counter made of two 8-bit halves. One control bit picks how the halves are used. In wide operation they form a single 16-bit counter. In split operation they are two separate 8-bit counters. Each active counter runs in one of two modes. In reload mode it loads a programmed start value when it overflows and raises its interrupt flag. In capture mode it runs freely, and an external edge strobe copies its value into a capture register and raises the flag.

Counting is gated by enables, not driven by separate clocks. Each half picks one of four tick inputs, and every tick input is a one-cycle pulse synchronous to `clk`. Software reaches counters, reload values, capture values and control bytes through a byte-wide register bus. Reads from that bus are registered. The capture strobe comes back out one cycle later, so the same edge can also feed an external interrupt line.

Top module: `split_cap_timer`

## Requirements
- R1: After synchronous reset, all eight registers read 0x00, and `irq_lo`, `irq_hi` and `cap_echo` are low.
- R2: A counter advances by one in a cycle only when its run bit (control bit 0) is set and its selected tick input is high. Otherwise it holds its value.
- R3: When control-low bit 4 (split) is 0, the halves count as one 16-bit value under the low control byte only. The low half's carry advances the high half in the same cycle. In reload mode, a step from 0xFFFF loads {reload-high, reload-low} and sets the high flag. The low flag is never set in this state.
- R4: In split reload mode (control bit 1 = 0), a half that steps from 0xFF loads its reload byte and sets its own flag.
- R5: In capture mode (control bit 1 = 1), the counter wraps from its maximum to 0 and sets no flag. When `cap_strobe` is high, the counter's value before that cycle's step is copied into the capture register, the flag is set, and counting carries on.
- R6: In split operation the halves count independently and may use different modes and tick sources. Both halves see the same `cap_strobe`.
- R7: Control bits 3:2 select the tick input: value n selects `src_tick[n]`.
- R8: Flags are sticky and appear as control bit 7 and on `irq_lo`/`irq_hi`. Writing a control byte with bit 7 = 0 clears that flag, and writing bit 7 = 1 does nothing to it. If a set event and a clear fall in the same cycle, the flag ends up set.
- R9: A bus write to a counter byte takes priority over counting or reloading in that cycle.
- R10: `cap_echo` is `cap_strobe` delayed by one cycle.
- R11: `bus_rdata` shows, one cycle after it is presented, the register at `bus_addr`. Addresses 0/1 are counter low/high, 2/3 reload low/high, 4/5 capture low/high (read only), and 6/7 control low/high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| src_tick | input | 4 | Count-enable pulses, one per source |
| cap_strobe | input | 1 | Edge-qualified capture pulse |
| cap_echo | output | 1 | Capture pulse delayed one cycle |
| irq_lo | output | 1 | Low-half flag |
| irq_hi | output | 1 | High-half (or wide) flag |

## Verification
The assertions assume that `cap_strobe` and every `src_tick` bit are single-cycle pulses in the `clk` domain. They also assume that a bus write lasts exactly one cycle. The bench drives all inputs at the falling edge and raises each strobe or tick for a single cycle, so the design never sees a pulse that straddles edges. The bench reaches corner cases, such as a clear colliding with an overflow or a write colliding with a tick, by putting the write and the pulse in the same driven cycle on purpose.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int unsigned SRC_W = 2;

  typedef struct packed {
    logic             split;
    logic [SRC_W-1:0] src;
    logic             cap;
    logic             run;
  } ctrl_t;

  localparam logic [1:0] GRP_CNT  = 2'd0;
  localparam logic [1:0] GRP_RLD  = 2'd1;
  localparam logic [1:0] GRP_CAP  = 2'd2;
  localparam logic [1:0] GRP_CTRL = 2'd3;
endpackage

// File: rtl/sct_src_mux.sv
module sct_src_mux #(
  parameter int unsigned NSRC = 4,
  localparam int unsigned SW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] ticks,
  input  logic [SW-1:0]   sel,
  input  logic            run,
  output logic            step
);
  always_comb step = run & ticks[sel];
endmodule

// File: rtl/sct_half_cnt.sv
module sct_half_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         load,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] rld,
  output logic [W-1:0] cnt,
  output logic         at_max
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wr)   cnt <= wr_data;
    else if (load) cnt <= rld;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  assign at_max = (cnt == {W{1'b1}});

  // R2: a plain step adds exactly one
  a_r2_inc: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && !wr) |=> (cnt == W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/sct_flag.sv
module sct_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R8: set beats clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    set |=> q);
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (q && !clr) |=> q);
endmodule

// File: rtl/split_cap_timer.sv
module split_cap_timer #(
  parameter int unsigned HALF_W = 8,
  parameter int unsigned NSRC   = 4,
  parameter int unsigned AW     = 3,
  parameter int unsigned DW     = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_tick,
  input  logic            cap_strobe,
  output logic            cap_echo,
  output logic            irq_lo,
  output logic            irq_hi
);
  import sct_pkg::*;

  localparam int unsigned NH  = 2;
  localparam int unsigned SW  = $clog2(NSRC);
  localparam int unsigned FLG = DW - 1;

  ctrl_t             ctrl    [NH];
  logic [HALF_W-1:0] cnt     [NH];
  logic [HALF_W-1:0] rld     [NH];
  logic [HALF_W-1:0] cap     [NH];
  logic [NH-1:0]     raw_step, step, at_max, ovf, load, cap_eff;
  logic [NH-1:0]     flag, flag_set, flag_clr, wr_cnt;
  logic              split;

  logic [1:0] grp;
  logic       half;
  assign grp  = bus_addr[2:1];
  assign half = bus_addr[0];

  assign split = ctrl[0].split;

  always_comb begin
    step[0]    = raw_step[0];
    step[1]    = split ? raw_step[1] : (raw_step[0] & at_max[0]);
    cap_eff[0] = ctrl[0].cap;
    cap_eff[1] = split ? ctrl[1].cap : ctrl[0].cap;
    ovf        = step & at_max;
    load[0]    = !cap_eff[0] & (split ? ovf[0] : ovf[1]);
    load[1]    = !cap_eff[1] & ovf[1];
    flag_set[0] = split & (cap_eff[0] ? cap_strobe : ovf[0]);
    flag_set[1] = cap_eff[1] ? cap_strobe : ovf[1];
  end

  for (genvar g = 0; g < NH; g++) begin : g_half
    logic sel_me;
    assign sel_me      = bus_wr && (half == 1'(g));
    assign wr_cnt[g]   = sel_me && (grp == GRP_CNT);
    assign flag_clr[g] = sel_me && (grp == GRP_CTRL) && !bus_wdata[FLG];

    sct_src_mux #(.NSRC(NSRC)) u_mux (
      .ticks (src_tick),
      .sel   (ctrl[g].src[SW-1:0]),
      .run   (ctrl[g].run),
      .step  (raw_step[g])
    );

    sct_half_cnt #(.W(HALF_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .inc     (step[g]),
      .load    (load[g]),
      .wr      (wr_cnt[g]),
      .wr_data (bus_wdata[HALF_W-1:0]),
      .rld     (rld[g]),
      .cnt     (cnt[g]),
      .at_max  (at_max[g])
    );

    sct_flag u_flag (
      .clk (clk),
      .rst (rst),
      .set (flag_set[g]),
      .clr (flag_clr[g]),
      .q   (flag[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        rld[g]  <= '0;
        cap[g]  <= '0;
        ctrl[g] <= '0;
      end else begin
        if (sel_me && grp == GRP_RLD) rld[g] <= bus_wdata[HALF_W-1:0];
        if (sel_me && grp == GRP_CTRL) begin
          ctrl[g]       <= ctrl_t'(bus_wdata[4:0]);
          ctrl[g].split <= (g == 0) ? bus_wdata[4] : 1'b0;
        end
        if (cap_strobe && cap_eff[g]) cap[g] <= cnt[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      cap_echo  <= 1'b0;
    end else begin
      cap_echo <= cap_strobe;
      case (grp)
        GRP_CNT:  bus_rdata <= DW'(cnt[half]);
        GRP_RLD:  bus_rdata <= DW'(rld[half]);
        GRP_CAP:  bus_rdata <= DW'(cap[half]);
        default:  bus_rdata <= {flag[half], 2'b00, ctrl[half]};
      endcase
    end
  end

  assign irq_lo = flag[0];
  assign irq_hi = flag[1];

  // R4: split reload takes the reload byte
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (split && !ctrl[0].cap && step[0] && at_max[0] && !wr_cnt[0])
    |=> (cnt[0] == $past(rld[0])));

  // R5: capture copies the pre-step count
  a_r5_capture: assert property (@(posedge clk) disable iff (rst)
    (cap_strobe && cap_eff[0]) |=> (cap[0] == $past(cnt[0])));

  // R3: carry ripples into the high half in the same cycle
  a_r3_wide_carry: assert property (@(posedge clk) disable iff (rst)
    (!split && raw_step[0] && cnt[0] == '1 && cnt[1] != '1 && wr_cnt == '0)
    |=> (cnt[0] == '0 && cnt[1] == HALF_W'($past(cnt[1]) + 1'b1)));

  // R3: low flag stays quiet in wide operation
  a_r3_lo_quiet: assert property (@(posedge clk) disable iff (rst)
    (!split && !irq_lo) |=> !irq_lo);

  // R10: strobe echo
  a_r10_echo: assert property (@(posedge clk) disable iff (rst)
    cap_strobe |=> cap_echo);
endmodule

// File: tb/tb_split_cap_timer.sv
module tb_split_cap_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] src_tick = '0;
  logic       cap_strobe = 1'b0;
  logic       cap_echo, irq_lo, irq_hi;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_cap_timer dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
    .cap_strobe(cap_strobe), .cap_echo(cap_echo),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d,
                    input logic [3:0] t = 4'b0, input logic s = 1'b0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; src_tick = t; cap_strobe = s;
    @(negedge clk);
    bus_wr = 1'b0; src_tick = '0; cap_strobe = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] t, input logic s = 1'b0);
    @(negedge clk);
    src_tick = t; cap_strobe = s;
    @(negedge clk);
    src_tick = '0; cap_strobe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, vh;
    logic [7:0] m;
    logic [15:0] m16;
    bit seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R11: reset values through the bus
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset reg", v, 0);
    end
    chk("R1 irq_lo", irq_lo, 0);
    chk("R1 irq_hi", irq_hi, 0);
    chk("R1 cap_echo", cap_echo, 0);

    // R2: run bit off blocks counting
    wr(6, 8'h10);
    pulse(4'b0001);
    rd(0, v); chk("R2 halted", v, 0);
    // R7: source select
    wr(6, 8'h19);
    rd(6, v); chk("R11 ctrl readback", v, 8'h19);
    pulse(4'b0001);
    rd(0, v); chk("R7 wrong source", v, 0);
    pulse(4'b0100);
    rd(0, v); chk("R2 step", v, 1);
    pulse(4'b1011);
    rd(0, v); chk("R7 other sources", v, 1);

    // R4: split reload sweep
    foreach (m16[i]) ;
    for (int p = 0; p < 2; p++) begin
      logic [7:0] r;
      r = (p == 0) ? 8'hFA : 8'hF3;
      wr(6, 8'h11); wr(0, r); wr(2, r); wr(6, 8'h11);
      m = r; seen = 0;
      for (int k = 0; k < 16; k++) begin
        pulse(4'b0001);
        if (m == 8'hFF) begin m = r; seen = 1; end else m = m + 1;
        rd(0, v); chk("R4 count", v, m);
        chk("R4 flag", irq_lo, seen);
      end
      rd(1, v); chk("R6 high untouched", v, 0);
    end

    // R8: sticky flag, write 1 ignored, write 0 clears, set wins
    wr(6, 8'h91);
    chk("R8 write one ignored", irq_lo, 1);
    wr(6, 8'h11);
    chk("R8 clear", irq_lo, 0);
    wr(0, 8'hFF);
    wr(6, 8'h11, 4'b0001);
    chk("R8 set wins", irq_lo, 1);
    rd(0, v); chk("R4 reload on collide", v, 8'hF3);

    // R9: write beats step
    wr(0, 8'h55, 4'b0001);
    rd(0, v); chk("R9 write priority", v, 8'h55);

    // R5 / R6: capture/capture on different sources
    wr(7, 8'h07); wr(6, 8'h1F); wr(1, 0); wr(0, 0);
    for (int k = 0; k < 5; k++) pulse(4'b0010);
    for (int k = 0; k < 3; k++) pulse(4'b1000);
    rd(1, v); chk("R6 high count", v, 5);
    rd(0, v); chk("R6 low count", v, 3);
    chk("R5 no flag yet", irq_hi, 0);
    pulse(4'b1010, 1'b1);
    rd(5, v); chk("R5 capture high", v, 5);
    rd(4, v); chk("R6 shared strobe low", v, 3);
    rd(1, v); chk("R5 keeps counting", v, 6);
    chk("R5 flag high", irq_hi, 1);
    chk("R6 flag low", irq_lo, 1);
    wr(7, 8'h07); wr(1, 8'hFE);
    for (int k = 0; k < 3; k++) pulse(4'b0010);
    rd(1, v); chk("R5 wrap", v, 1);
    chk("R5 wrap no flag", irq_hi, 0);

    // R10: echo timing
    @(negedge clk); cap_strobe = 1'b1;
    @(negedge clk); cap_strobe = 1'b0;
    chk("R10 echo high", cap_echo, 1);
    @(negedge clk);
    chk("R10 echo low", cap_echo, 0);

    // R3: wide reload
    wr(6, 8'h01); wr(7, 8'h00);
    wr(2, 8'h34); wr(3, 8'h12); wr(0, 8'hFD); wr(1, 8'hFF);
    pulse(4'b0001); pulse(4'b0001);
    chk("R3 no flag before wrap", irq_hi, 0);
    pulse(4'b0001);
    rd(0, v); rd(1, vh);
    chk("R3 wide reload", {vh, v}, 16'h1234);
    chk("R3 high flag", irq_hi, 1);
    chk("R3 low flag quiet", irq_lo, 0);
    wr(0, 8'hFF); wr(1, 8'h00);
    pulse(4'b0001);
    rd(0, v); rd(1, vh);
    chk("R3 carry", {vh, v}, 16'h0100);

    // R3: wide sweep across the wrap
    wr(2, 8'hE8); wr(3, 8'hFF); wr(0, 8'hF0); wr(1, 8'hFF);
    m16 = 16'hFFF0;
    for (int k = 0; k < 40; k++) begin
      pulse(4'b0001);
      m16 = (m16 == 16'hFFFF) ? 16'hFFE8 : m16 + 1;
      rd(0, v); rd(1, vh);
      chk("R3 wide sweep", {vh, v}, m16);
    end

    // R5 / R3: wide capture
    wr(6, 8'h03); wr(7, 8'h00); wr(0, 8'hFE); wr(1, 8'h00);
    pulse(4'b0001);
    pulse(4'b0001, 1'b1);
    rd(4, v); rd(5, vh);
    chk("R5 wide capture", {vh, v}, 16'h00FF);
    rd(0, v); rd(1, vh);
    chk("R5 wide continues", {vh, v}, 16'h0100);
    chk("R5 wide flag", irq_hi, 1);
    chk("R3 low flag in wide capture", irq_lo, 0);
    wr(7, 8'h00); wr(0, 8'hFF); wr(1, 8'hFF);
    pulse(4'b0001);
    rd(0, v); rd(1, vh);
    chk("R5 wide wrap", {vh, v}, 0);
    chk("R5 wide wrap no flag", irq_hi, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule